// File: doc/BRIEF.md
# Rectangle Sprite Rasterizer

This block turns a list of rectangle sprites into pixels in a small frame buffer. Each list entry occupies two words in an external sprite memory. The first word holds the rectangle's corners and the second holds its colour and a draw-enable bit. When `start` is pulsed, the block reads the entries from lowest to highest index. For each enabled, well-formed entry it writes one pixel per clock into the frame buffer, row by row. It then raises `done` for one cycle.

The frame buffer is not cleared before a pass, and pixels outside every rectangle keep their old contents. Because a later entry overwrites an earlier one, software normally uses entry 0 as a full-screen background. Leaving the background disabled lets several passes build up one picture.

States: `ST_IDLE` (wait for start), `ST_REQ_GEO` (present the corner word address), `ST_LOAD_GEO` (capture the corner word and present the colour word address), `ST_LOAD_COL` (capture the colour word), `ST_CHECK` (decide whether the entry draws), `ST_PAINT` (one pixel per cycle), `ST_NEXT` (advance the entry index) and `ST_FINISH` (pulse done).

Transitions: IDLE→REQ_GEO on start. REQ_GEO→LOAD_GEO→LOAD_COL→CHECK unconditionally. CHECK→PAINT when the entry draws, otherwise CHECK→NEXT. PAINT→PAINT until the last pixel, then PAINT→NEXT. NEXT→REQ_GEO while entries remain, otherwise NEXT→FINISH. FINISH→IDLE.

Top module: `sprite_raster`

## Requirements
- R1: Entry k keeps its corner word at `spr_addr` 2k and its colour word at 2k+1. Memory data arrives on `spr_rdata` one cycle after the address. The corner word carries the left column in bits 15:12, the right column in 11:8, the top row in 7:4 and the bottom row in 3:0. A pixel at column x and row y is written to `fb_addr` = y*16 + x.
- R2: Rectangle bounds are inclusive, so an entry covers every column from left to right and every row from top to bottom, both ends included.
- R3: In the colour word, bits 15:1 are the pixel colour and bit 0 enables drawing. An entry whose bit 0 is 0 writes no pixel. All pixels of a rectangle carry the same `fb_data`.
- R4: An entry whose left column exceeds its right column, or whose top row exceeds its bottom row, writes no pixel.
- R5: Entries are drawn in ascending index order, so where rectangles overlap the pixel ends with the colour of the highest-indexed enabled entry covering it.
- R6: The block never clears the frame buffer. Pixels that no drawing entry covers keep the value they had before the pass.
- R7: Inside a rectangle, pixels are written one per clock with `fb_we` continuously high, in row-major order: columns ascend within a row and rows ascend.
- R8: Let P be the number of pixels written in a pass. The edge that samples `start` is followed by 5*32 + P further edges, and `done` is high for exactly the one cycle after the last of these. `fb_we` is never high together with `done`.
- R9: `start` is ignored while a pass is in progress. A pulse mid-pass neither changes the pass length nor causes a second pass.
- R10: During reset and after reset, `done` and `fb_we` are low. After `done` the block stays idle with no writes until the next `start`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | One-cycle request to run a pass over the list |
| spr_addr | output | 6 | Sprite memory word address (entry index, word select in bit 0) |
| spr_rdata | input | 16 | Sprite memory read data, one cycle after the address |
| fb_we | output | 1 | Frame buffer write enable |
| fb_addr | output | 8 | Frame buffer pixel address, row in the upper nibble |
| fb_data | output | 15 | Pixel colour to write |
| done | output | 1 | One-cycle pulse at the end of a pass |

## Verification
Single-entry scenes are placed at scattered list indices. They cover a full screen, a single pixel, a full row, a full column, a bottom-right corner, a disabled entry and entries inverted in each axis. Together they separate the corner-field positions, the inclusive bounds, the enable bit and the malformed-entry rule. Every pixel of the frame is compared against a frame filled with a distinct per-pixel pattern, so a stray write or a clear shows up. Layered scenes with overlapping rectangles at indices 0, 10 and 31, and a second pass without refilling, distinguish draw order from clearing. A small rectangle's write sequence checks row-major order. A start pulse injected mid-pass shows whether the pass restarts or runs twice.

// File: rtl/sprite_raster_pkg.sv
package sprite_raster_pkg;

    typedef enum logic [2:0] {
        ST_IDLE     = 3'd0,
        ST_REQ_GEO  = 3'd1,
        ST_LOAD_GEO = 3'd2,
        ST_LOAD_COL = 3'd3,
        ST_CHECK    = 3'd4,
        ST_PAINT    = 3'd5,
        ST_NEXT     = 3'd6,
        ST_FINISH   = 3'd7
    } raster_state_e;

    // number of corner fields packed into the geometry word
    localparam int unsigned GEO_FIELDS = 4;

endpackage

// File: rtl/sprite_entry_decode.sv
module sprite_entry_decode #(
    parameter int unsigned COORD_W = 4,
    parameter int unsigned WORD_W  = 16
) (
    input  logic [WORD_W-1:0]  geo_word,
    input  logic [WORD_W-1:0]  col_word,
    output logic [COORD_W-1:0] x_lo,
    output logic [COORD_W-1:0] x_hi,
    output logic [COORD_W-1:0] y_lo,
    output logic [COORD_W-1:0] y_hi,
    output logic [WORD_W-2:0]  colour,
    output logic               draw_ok
);
    import sprite_raster_pkg::*;

    logic [COORD_W-1:0] field [GEO_FIELDS];

    // fields from most significant to least significant: x_lo, x_hi, y_lo, y_hi
    for (genvar g = 0; g < GEO_FIELDS; g++) begin : g_field
        assign field[g] = geo_word[WORD_W-1-g*COORD_W -: COORD_W];
    end

    assign x_lo   = field[0];
    assign x_hi   = field[1];
    assign y_lo   = field[2];
    assign y_hi   = field[3];
    assign colour = col_word[WORD_W-1:1];

    always_comb begin
        draw_ok = col_word[0] && (x_lo <= x_hi) && (y_lo <= y_hi);
    end

endmodule

// File: rtl/rect_walker.sv
module rect_walker #(
    parameter int unsigned COORD_W = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               load,
    input  logic               step,
    input  logic [COORD_W-1:0] x_lo,
    input  logic [COORD_W-1:0] x_hi,
    input  logic [COORD_W-1:0] y_lo,
    input  logic [COORD_W-1:0] y_hi,
    output logic [COORD_W-1:0] cur_x,
    output logic [COORD_W-1:0] cur_y,
    output logic               last
);
    logic row_end;

    assign row_end = (cur_x == x_hi);
    assign last    = row_end && (cur_y == y_hi);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cur_x <= '0;
            cur_y <= '0;
        end else if (load) begin
            cur_x <= x_lo;
            cur_y <= y_lo;
        end else if (step) begin
            if (row_end) begin
                cur_x <= x_lo;
                cur_y <= cur_y + 1'b1;
            end else begin
                cur_x <= cur_x + 1'b1;
            end
        end
    end

endmodule

// File: rtl/raster_ctrl.sv
module raster_ctrl #(
    parameter int unsigned ENTRIES = 32,
    parameter int unsigned WORD_W  = 16,
    localparam int unsigned IDX_W  = $clog2(ENTRIES)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [WORD_W-1:0] spr_rdata,
    input  logic              draw_ok,
    input  logic              walk_last,
    output logic [IDX_W-1:0]  idx,
    output logic [WORD_W-1:0] geo_q,
    output logic [WORD_W-1:0] col_q,
    output logic              word_sel,
    output logic              walk_load,
    output logic              walk_step,
    output logic              paint_en,
    output logic              done
);
    import sprite_raster_pkg::*;

    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(ENTRIES - 1);

    raster_state_e state, state_nx;
    logic          last_entry;

    assign last_entry = (idx == LAST_IDX);

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    // transitions
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE:     if (start) state_nx = ST_REQ_GEO;
            ST_REQ_GEO:  state_nx = ST_LOAD_GEO;
            ST_LOAD_GEO: state_nx = ST_LOAD_COL;
            ST_LOAD_COL: state_nx = ST_CHECK;
            ST_CHECK:    state_nx = draw_ok ? ST_PAINT : ST_NEXT;
            ST_PAINT:    if (walk_last) state_nx = ST_NEXT;
            ST_NEXT:     state_nx = last_entry ? ST_FINISH : ST_REQ_GEO;
            ST_FINISH:   state_nx = ST_IDLE;
            default:     state_nx = ST_IDLE;
        endcase
    end

    // entry index and captured words
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            idx   <= '0;
            geo_q <= '0;
            col_q <= '0;
        end else begin
            if (state == ST_IDLE && start)         idx   <= '0;
            if (state == ST_NEXT && !last_entry)   idx   <= idx + 1'b1;
            if (state == ST_LOAD_GEO)              geo_q <= spr_rdata;
            if (state == ST_LOAD_COL)              col_q <= spr_rdata;
        end
    end

    // outputs
    always_comb begin
        word_sel  = 1'b0;
        walk_load = 1'b0;
        walk_step = 1'b0;
        paint_en  = 1'b0;
        done      = 1'b0;
        unique case (state)
            ST_LOAD_GEO: word_sel  = 1'b1;
            ST_CHECK:    walk_load = draw_ok;
            ST_PAINT: begin
                walk_step = 1'b1;
                paint_en  = 1'b1;
            end
            ST_FINISH:   done = 1'b1;
            default: ;
        endcase
    end

endmodule

// File: rtl/sprite_raster.sv
module sprite_raster #(
    parameter int unsigned ENTRIES = 32,
    parameter int unsigned COORD_W = 4,
    parameter int unsigned WORD_W  = 16
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         start,
    output logic [$clog2(ENTRIES):0]     spr_addr,
    input  logic [WORD_W-1:0]            spr_rdata,
    output logic                         fb_we,
    output logic [2*COORD_W-1:0]         fb_addr,
    output logic [WORD_W-2:0]            fb_data,
    output logic                         done
);
    localparam int unsigned IDX_W = $clog2(ENTRIES);

    logic [IDX_W-1:0]   idx;
    logic [WORD_W-1:0]  geo_q, col_q;
    logic               word_sel, walk_load, walk_step, paint_en;
    logic               draw_ok, walk_last;
    logic [COORD_W-1:0] x_lo, x_hi, y_lo, y_hi, cur_x, cur_y;
    logic [WORD_W-2:0]  colour;

    raster_ctrl #(.ENTRIES(ENTRIES), .WORD_W(WORD_W)) u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (start),
        .spr_rdata (spr_rdata),
        .draw_ok   (draw_ok),
        .walk_last (walk_last),
        .idx       (idx),
        .geo_q     (geo_q),
        .col_q     (col_q),
        .word_sel  (word_sel),
        .walk_load (walk_load),
        .walk_step (walk_step),
        .paint_en  (paint_en),
        .done      (done)
    );

    sprite_entry_decode #(.COORD_W(COORD_W), .WORD_W(WORD_W)) u_decode (
        .geo_word (geo_q),
        .col_word (col_q),
        .x_lo     (x_lo),
        .x_hi     (x_hi),
        .y_lo     (y_lo),
        .y_hi     (y_hi),
        .colour   (colour),
        .draw_ok  (draw_ok)
    );

    rect_walker #(.COORD_W(COORD_W)) u_walker (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (walk_load),
        .step  (walk_step),
        .x_lo  (x_lo),
        .x_hi  (x_hi),
        .y_lo  (y_lo),
        .y_hi  (y_hi),
        .cur_x (cur_x),
        .cur_y (cur_y),
        .last  (walk_last)
    );

    assign spr_addr = {idx, word_sel};
    assign fb_we    = paint_en;
    assign fb_addr  = {cur_y, cur_x};
    assign fb_data  = colour;

endmodule

// File: rtl/sprite_raster_checks.sv
module sprite_raster_checks #(
    parameter int unsigned COORD_W = 4,
    parameter int unsigned WORD_W  = 16
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 fb_we,
    input logic [2*COORD_W-1:0] fb_addr,
    input logic [WORD_W-2:0]    fb_data,
    input logic                 done
);
    logic [COORD_W-1:0] px, py;
    assign px = fb_addr[COORD_W-1:0];
    assign py = fb_addr[2*COORD_W-1:COORD_W];

    // R8: done lasts exactly one cycle
    assert_done_single_R8: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R8: no pixel write while done is shown
    assert_no_write_at_done_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !(done && fb_we));

    // R7: back-to-back writes advance one column or start the next row
    assert_row_major_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (fb_we && $past(fb_we)) |->
            ((py == $past(py) && px == $past(px) + 1'b1) ||
             (py == $past(py) + 1'b1 && px <= $past(px))));

    // R3: one colour across a run of writes
    assert_colour_steady_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (fb_we && $past(fb_we)) |-> $stable(fb_data));

    // R10: quiet outputs on leaving reset
    assert_reset_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (!done && !fb_we));

endmodule

bind sprite_raster sprite_raster_checks #(.COORD_W(COORD_W), .WORD_W(WORD_W)) u_checks (
    .clk     (clk),
    .rst_n   (rst_n),
    .fb_we   (fb_we),
    .fb_addr (fb_addr),
    .fb_data (fb_data),
    .done    (done)
);

// File: tb/test_sprite_raster.sv
`timescale 1ns/1ps
module test_sprite_raster;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        start;
    logic [5:0]  spr_addr;
    logic [15:0] spr_rdata;
    logic        fb_we;
    logic [7:0]  fb_addr;
    logic [14:0] fb_data;
    logic        done;

    always #2.5 clk = ~clk;

    sprite_raster i_sprite_raster (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (start),
        .spr_addr  (spr_addr),
        .spr_rdata (spr_rdata),
        .fb_we     (fb_we),
        .fb_addr   (fb_addr),
        .fb_data   (fb_data),
        .done      (done)
    );

    // bench-side memories
    logic [15:0] sram   [64];
    logic [14:0] fb     [256];
    logic [14:0] exp_fb [256];
    logic [7:0]  wlog   [4096];
    int          wcount = 0;
    logic        fill_req = 1'b0;
    int          fill_seed = 0;

    always @(posedge clk) spr_rdata <= sram[spr_addr];

    always @(posedge clk) begin
        if (fill_req) begin
            for (int p = 0; p < 256; p++) fb[p] <= 15'(p * 97 + fill_seed);
        end else if (fb_we) begin
            fb[fb_addr] <= fb_data;
        end
        if (fb_we) begin
            wlog[wcount[11:0]] <= fb_addr;
            wcount <= wcount + 1;
        end
    end

    int nchk = 0;
    int nerr = 0;
    bit finished = 1'b0;

    // stimulus table: corner word, colour word, entry index, pixels expected
    localparam logic [63:0] VEC [8] = '{
        {16'h0F0F, 16'h2AAB, 16'd0,  16'd256},  // full screen
        {16'h3355, 16'h4C01, 16'd5,  16'd1},    // single pixel
        {16'h0F77, 16'h0003, 16'd10, 16'd16},   // one row
        {16'h220F, 16'hFFFF, 16'd15, 16'd16},   // one column
        {16'h0F0F, 16'h2AAA, 16'd20, 16'd0},    // disabled
        {16'h5300, 16'h1235, 16'd25, 16'd0},    // inverted columns
        {16'h0190, 16'h1235, 16'd30, 16'd0},    // inverted rows
        {16'hEFEF, 16'h7777, 16'd31, 16'd4}     // bottom-right corner
    };

    task automatic check(input bit ok, input string tag, input string what,
                         input int act, input int exp);
        nchk++;
        if (!ok) begin
            nerr++;
            $display("FAIL %s %s: actual=%0d expected=%0d", tag, what, act, exp);
        end
    endtask

    task automatic clear_sram();
        for (int i = 0; i < 64; i++) sram[i] = 16'h0000;
    endtask

    task automatic fill_fb(input int seed);
        @(negedge clk);
        fill_seed = seed;
        fill_req  = 1'b1;
        @(negedge clk);
        fill_req  = 1'b0;
    endtask

    // expected frame from the current frame plus the list, in index order
    task automatic build_expect(output int npix);
        npix = 0;
        for (int p = 0; p < 256; p++) exp_fb[p] = fb[p];
        for (int e = 0; e < 32; e++) begin
            automatic logic [15:0] w0 = sram[2*e];
            automatic logic [15:0] w1 = sram[2*e+1];
            if (w1[0] && w0[15:12] <= w0[11:8] && w0[7:4] <= w0[3:0]) begin
                for (int y = int'(w0[7:4]); y <= int'(w0[3:0]); y++)
                    for (int x = int'(w0[15:12]); x <= int'(w0[11:8]); x++) begin
                        exp_fb[y*16+x] = w1[15:1];
                        npix++;
                    end
            end
        end
    endtask

    task automatic run_frame(input int inject, output int cycles,
                             output int dones, output int late_writes);
        @(negedge clk);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        cycles = 0;
        dones = 0;
        late_writes = 0;
        while (!done && cycles < 20000) begin
            cycles++;
            start = (cycles == inject);
            @(negedge clk);
        end
        start = 1'b0;
        if (done) dones = 1;
        for (int k = 0; k < 20; k++) begin
            @(negedge clk);
            if (done)  dones++;
            if (fb_we) late_writes++;
        end
    endtask

    task automatic compare_fb(input string tag);
        int mism = 0;
        int first = -1;
        for (int p = 0; p < 256; p++)
            if (fb[p] !== exp_fb[p]) begin
                mism++;
                if (first < 0) first = p;
            end
        if (first >= 0)
            check(1'b0, tag, $sformatf("pixel %0d colour", first),
                  int'(fb[first]), int'(exp_fb[first]));
        check(mism == 0, tag, "mismatching pixels", mism, 0);
    endtask

    initial begin
        int cyc, dn, late, npix, base;
        rst_n = 1'b0;
        start = 1'b0;
        clear_sram();
        repeat (4) @(negedge clk);
        check(done == 1'b0 && fb_we == 1'b0, "R10", "outputs in reset",
              int'({done, fb_we}), 0);
        rst_n = 1'b1;
        @(negedge clk);
        check(done == 1'b0 && fb_we == 1'b0, "R10", "outputs after reset",
              int'({done, fb_we}), 0);

        // table walk: R1 R2 R3 R4 R6 R8
        for (int v = 0; v < 8; v++) begin
            clear_sram();
            sram[2*int'(VEC[v][31:16])]   = VEC[v][63:48];
            sram[2*int'(VEC[v][31:16])+1] = VEC[v][47:32];
            fill_fb(v * 13 + 1);
            build_expect(npix);
            check(npix == int'(VEC[v][15:0]), "R2", $sformatf("vector %0d model pixels", v),
                  npix, int'(VEC[v][15:0]));
            run_frame(-1, cyc, dn, late);
            compare_fb($sformatf("R1 R2 R3 R4 R6 vector %0d", v));
            check(cyc == 160 + int'(VEC[v][15:0]), "R8", $sformatf("vector %0d cycles to done", v),
                  cyc, 160 + int'(VEC[v][15:0]));
            check(dn == 1, "R8", $sformatf("vector %0d done pulses", v), dn, 1);
            check(late == 0, "R10", $sformatf("vector %0d writes after done", v), late, 0);
        end

        // R5: layered scene
        clear_sram();
        sram[0]  = 16'h0F0F; sram[1]  = {15'h0111, 1'b1};
        sram[20] = 16'h0A0A; sram[21] = {15'h0222, 1'b1};
        sram[62] = 16'h4567; sram[63] = {15'h0333, 1'b1};
        fill_fb(7);
        build_expect(npix);
        run_frame(-1, cyc, dn, late);
        compare_fb("R5 layered");
        check(fb[6*16+4] == 15'h0333, "R5", "top entry wins", int'(fb[6*16+4]), 'h333);
        check(fb[0] == 15'h0222, "R5", "middle over background", int'(fb[0]), 'h222);
        check(fb[255] == 15'h0111, "R5", "background pixel", int'(fb[255]), 'h111);
        check(cyc == 160 + npix, "R8", "layered cycles", cyc, 160 + npix);

        // R6: second pass without refill, no background
        clear_sram();
        sram[14] = 16'h2233; sram[15] = {15'h0444, 1'b1};
        build_expect(npix);
        run_frame(-1, cyc, dn, late);
        compare_fb("R6 second pass");
        check(fb[0] == 15'h0222, "R6", "old pixel kept", int'(fb[0]), 'h222);
        check(fb[3*16+2] == 15'h0444, "R6", "new pixel drawn", int'(fb[3*16+2]), 'h444);

        // R7: write order inside a 3x3 rectangle
        clear_sram();
        sram[10] = 16'h1324; sram[11] = {15'h0555, 1'b1};
        base = wcount;
        run_frame(-1, cyc, dn, late);
        check(wcount - base == 9, "R7", "write count", wcount - base, 9);
        begin
            int k = 0;
            int bad = 0;
            for (int y = 2; y <= 4; y++)
                for (int x = 1; x <= 3; x++) begin
                    if (wlog[12'(base + k)] != 8'(y*16+x)) bad++;
                    k++;
                end
            check(bad == 0, "R7", "row-major sequence errors", bad, 0);
        end
        check(cyc == 169, "R7", "one pixel per clock", cyc, 169);

        // R9: start during a pass
        clear_sram();
        sram[0]  = 16'h0F0F; sram[1]  = {15'h0666, 1'b1};
        sram[40] = 16'h1122; sram[41] = {15'h0777, 1'b1};
        fill_fb(3);
        build_expect(npix);
        run_frame(50, cyc, dn, late);
        check(cyc == 160 + npix, "R9", "pass length with mid-pass start", cyc, 160 + npix);
        check(dn == 1, "R9", "single done", dn, 1);
        check(late == 0, "R9", "no second pass", late, 0);
        compare_fb("R9 frame");

        finished = 1'b1;
        $display("Result: errors=%0d of %0d checks", nerr, nchk);
        $finish;
    end

    initial begin
        #1000000;
        if (!finished) begin
            nchk++;
            nerr++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", nerr, nchk);
            $finish;
        end
    end

endmodule